// File: doc/BRIEF.md
# Programmable Interval Timer with Coherent Byte Access

This block is a down-counting interval timer. Software reaches it through a narrow register bus with byte-wide data and separate read and write strobes. On each timebase tick from an outside prescaler the count drops by one. When a tick arrives while the count is zero, the count reloads from a programmed period value and the block raises a single-cycle interrupt pulse. The count is wider than the bus, so software reads it in two pieces. It also writes the period in two pieces.

Reading the count's low byte freezes a copy of the upper count bits in a holding register. A later read of the upper register returns that frozen copy, so the two reads form one coherent value however many ticks fall between them. The period is written low byte first. That byte waits in a staging register until the write of the upper bits commits both parts at once. The counter therefore never reloads from a period that is only half updated. The bus location of each register is a parameter. The defaults place count-low, count-high, period-low and period-high at 0x26, 0x27, 0x28 and 0x29.

Top module: `pit_interval_timer`

## Requirements
- R1: After reset the count, the active period, the staging byte and the holding register are zero, `irq_o` is low and `rd_data_o` is zero.
- R2: A cycle with `tick_i` high and a nonzero count lowers the count by one. A cycle without `tick_i` leaves the count unchanged.
- R3: A tick that finds the count at zero loads the active period P into the count. When P is nonzero, `irq_o` is high for exactly the one cycle after that tick, which gives an interrupt every P+1 ticks.
- R4: While the active period is zero, a tick at count zero leaves the count at zero and raises no interrupt.
- R5: A read at the count-low address (default 0x26) returns count bits 7:0. In the same cycle it copies count bits 11:8 into the holding register.
- R6: A read at the count-high address (default 0x27) returns the holding register in bits 3:0, not the live count.
- R7: A write at the period-low address (default 0x28) only stores the byte in staging. The active period and the reload timing stay unchanged.
- R8: A write at the period-high address (default 0x29) makes the active period {write data bits 3:0, staged byte}.
- R9: Reads at 0x28 and 0x29 return the committed active period, never the staged byte.
- R10: Bits 7:4 of data read from 0x27 and 0x29 are always zero. Bits 7:4 written at 0x29 are discarded.
- R11: Writes at 0x26 and 0x27 change no state.
- R12: Read data updates one clock after a cycle with `rd_en_i` high and otherwise holds. A read at any unmapped address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase tick, one cycle per count step |
| addr_i | input | 8 | Register address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 8 | Registered read data |
| irq_o | output | 1 | Single-cycle interrupt pulse on expiry |

## Verification
The properties assume that `tick_i` is a single-cycle strobe. They also assume that the period is changed only through the high-address write, and that read data is sampled only in the cycle after a read strobe. The bench drives every strobe for exactly one cycle at the falling edge and samples outputs one falling edge later. It never reads and writes in the same cycle, so each register access and each tick can be related unambiguously to the value that follows it. Reload periods are measured by counting ticks between interrupt pulses rather than by peeking at the counter.

// File: rtl/pit_pkg.sv
package pit_pkg;

   // Register bus geometry shared by the timer and its checker
   localparam int unsigned PIT_BUS_W  = 8;
   localparam int unsigned PIT_ADDR_W = 8;
   localparam int unsigned PIT_CNT_W  = 12;

   // Decoded register selection
   typedef enum logic [2:0] {
      SEL_NONE   = 3'd0,
      SEL_CNT_LO = 3'd1,
      SEL_CNT_HI = 3'd2,
      SEL_PRD_LO = 3'd3,
      SEL_PRD_HI = 3'd4
   } pit_sel_e;

endpackage

// File: rtl/pit_regbank.sv
module pit_regbank
   import pit_pkg::*;
#(
   parameter int unsigned            BUS_W   = PIT_BUS_W,
   parameter int unsigned            ADDR_W  = PIT_ADDR_W,
   parameter int unsigned            CNT_W   = PIT_CNT_W,
   parameter logic [ADDR_W-1:0]      A_CNT_LO = 'h26,
   parameter logic [ADDR_W-1:0]      A_CNT_HI = 'h27,
   parameter logic [ADDR_W-1:0]      A_PRD_LO = 'h28,
   parameter logic [ADDR_W-1:0]      A_PRD_HI = 'h29
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_en_i,
   input  logic [BUS_W-1:0]  wr_data_i,
   input  logic              rd_en_i,
   input  logic [CNT_W-1:0]  count_i,
   output logic [CNT_W-1:0]  period_o,
   output logic [BUS_W-1:0]  rd_data_o
);

   localparam int unsigned HI_W = CNT_W - BUS_W;

   pit_sel_e           sel;
   logic [BUS_W-1:0]   stage_q;
   logic [HI_W-1:0]    hold_q;
   logic [CNT_W-1:0]   period_q;
   logic [BUS_W-1:0]   rd_next;

   // Address decode
   always_comb begin
      if      (addr_i == A_CNT_LO) sel = SEL_CNT_LO;
      else if (addr_i == A_CNT_HI) sel = SEL_CNT_HI;
      else if (addr_i == A_PRD_LO) sel = SEL_PRD_LO;
      else if (addr_i == A_PRD_HI) sel = SEL_PRD_HI;
      else                         sel = SEL_NONE;
   end

   // Staged period write: low byte waits, high write commits both halves
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stage_q  <= '0;
         period_q <= '0;
      end else if (wr_en_i) begin
         if (sel == SEL_PRD_LO) begin
            stage_q <= wr_data_i;
         end
         if (sel == SEL_PRD_HI) begin
            period_q <= {wr_data_i[HI_W-1:0], stage_q};
         end
      end
   end

   // Holding register: freezes the upper count bits on a low-byte read
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hold_q <= '0;
      end else if (rd_en_i && sel == SEL_CNT_LO) begin
         hold_q <= count_i[CNT_W-1:BUS_W];
      end
   end

   // Read mux; upper register reads are zero-extended
   always_comb begin
      unique case (sel)
         SEL_CNT_LO: rd_next = count_i[BUS_W-1:0];
         SEL_CNT_HI: rd_next = BUS_W'(hold_q);
         SEL_PRD_LO: rd_next = period_q[BUS_W-1:0];
         SEL_PRD_HI: rd_next = BUS_W'(period_q[CNT_W-1:BUS_W]);
         default:    rd_next = '0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rd_data_o <= '0;
      end else if (rd_en_i) begin
         rd_data_o <= rd_next;
      end
   end

   assign period_o = period_q;

endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
   parameter int unsigned CNT_W = pit_pkg::PIT_CNT_W
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] period_i,
   output logic [CNT_W-1:0] count_o,
   output logic             irq_o
);

   logic [CNT_W-1:0] count_q;
   logic             at_zero;
   logic             expire;

   assign at_zero = (count_q == '0);
   assign expire  = tick_i && at_zero;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         count_q <= '0;
      end else if (tick_i) begin
         if (at_zero) count_q <= period_i;
         else         count_q <= count_q - CNT_W'(1);
      end
   end

   // Interrupt only for a real period; a zero period keeps the timer idle
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_o <= 1'b0;
      else         irq_o <= expire && (period_i != '0);
   end

   assign count_o = count_q;

endmodule

// File: rtl/pit_interval_timer.sv
module pit_interval_timer
   import pit_pkg::*;
#(
   parameter int unsigned       BUS_W    = PIT_BUS_W,
   parameter int unsigned       ADDR_W   = PIT_ADDR_W,
   parameter int unsigned       CNT_W    = PIT_CNT_W,
   parameter logic [ADDR_W-1:0] A_CNT_LO = 'h26,
   parameter logic [ADDR_W-1:0] A_CNT_HI = 'h27,
   parameter logic [ADDR_W-1:0] A_PRD_LO = 'h28,
   parameter logic [ADDR_W-1:0] A_PRD_HI = 'h29
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_en_i,
   input  logic [BUS_W-1:0]  wr_data_i,
   input  logic              rd_en_i,
   output logic [BUS_W-1:0]  rd_data_o,
   output logic              irq_o
);

   // Elaboration checks: the count must span more than one bus word and at most two
   generate
      if (CNT_W <= BUS_W || CNT_W > 2 * BUS_W) begin : g_bad_width
         $error("pit_interval_timer: CNT_W must lie in (BUS_W, 2*BUS_W]");
      end
      if (A_CNT_LO == A_CNT_HI || A_CNT_LO == A_PRD_LO || A_CNT_LO == A_PRD_HI ||
          A_CNT_HI == A_PRD_LO || A_CNT_HI == A_PRD_HI || A_PRD_LO == A_PRD_HI) begin : g_bad_map
         $error("pit_interval_timer: register addresses must be distinct");
      end
   endgenerate

   logic [CNT_W-1:0] count_w;
   logic [CNT_W-1:0] period_w;

   pit_regbank #(
      .BUS_W    (BUS_W),
      .ADDR_W   (ADDR_W),
      .CNT_W    (CNT_W),
      .A_CNT_LO (A_CNT_LO),
      .A_CNT_HI (A_CNT_HI),
      .A_PRD_LO (A_PRD_LO),
      .A_PRD_HI (A_PRD_HI)
   ) i_regbank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .addr_i    (addr_i),
      .wr_en_i   (wr_en_i),
      .wr_data_i (wr_data_i),
      .rd_en_i   (rd_en_i),
      .count_i   (count_w),
      .period_o  (period_w),
      .rd_data_o (rd_data_o)
   );

   pit_counter #(
      .CNT_W (CNT_W)
   ) i_counter (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .period_i (period_w),
      .count_o  (count_w),
      .irq_o    (irq_o)
   );

endmodule

// File: rtl/pit_interval_timer_chk.sv
module pit_interval_timer_chk #(
   parameter int unsigned       BUS_W    = 8,
   parameter int unsigned       ADDR_W   = 8,
   parameter int unsigned       CNT_W    = 12,
   parameter logic [ADDR_W-1:0] A_CNT_HI = 'h27,
   parameter logic [ADDR_W-1:0] A_PRD_HI = 'h29
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              tick_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic              wr_en_i,
   input logic              rd_en_i,
   input logic [BUS_W-1:0]  rd_data_o,
   input logic              irq_o,
   input logic [CNT_W-1:0]  count_w,
   input logic [CNT_W-1:0]  period_w
);

   localparam int unsigned HI_W = CNT_W - BUS_W;

   assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && count_w != '0) |=> (count_w == $past(count_w) - CNT_W'(1)));

   assert_count_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i |=> $stable(count_w));

   assert_reload_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && count_w == '0) |=> (count_w == $past(period_w)));

   assert_irq_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |=> !irq_o);

   assert_irq_after_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> $past(tick_i));

   assert_zero_period_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (period_w == '0 && count_w == '0) |=> (count_w == '0 && !irq_o));

   assert_period_commit_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && addr_i == A_PRD_HI) |=> $stable(period_w));

   assert_reserved_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && (addr_i == A_CNT_HI || addr_i == A_PRD_HI)) |=>
         (rd_data_o[BUS_W-1:HI_W] == '0));

   assert_rdata_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_en_i |=> $stable(rd_data_o));

endmodule

bind pit_interval_timer pit_interval_timer_chk #(
   .BUS_W    (BUS_W),
   .ADDR_W   (ADDR_W),
   .CNT_W    (CNT_W),
   .A_CNT_HI (A_CNT_HI),
   .A_PRD_HI (A_PRD_HI)
) i_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .tick_i    (tick_i),
   .addr_i    (addr_i),
   .wr_en_i   (wr_en_i),
   .rd_en_i   (rd_en_i),
   .rd_data_o (rd_data_o),
   .irq_o     (irq_o),
   .count_w   (count_w),
   .period_w  (period_w)
);

// File: tb/test_pit_interval_timer.sv
module test_pit_interval_timer;

   localparam time CLK_PERIOD = 10ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [7:0] addr = '0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic       irq;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pit_interval_timer i_pit_interval_timer (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .tick_i    (tick),
      .addr_i    (addr),
      .wr_en_i   (wr_en),
      .wr_data_i (wr_data),
      .rd_en_i   (rd_en),
      .rd_data_o (rd_data),
      .irq_o     (irq)
   );

   task automatic check(string req, int actual, int expected);
      n_tests++;
      if (actual != expected) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
      end
   endtask

   task automatic bus_write(logic [7:0] a, logic [7:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_read(logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      d = rd_data;
   endtask

   task automatic tick_once(output bit hit);
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      hit = irq;
   endtask

   // Ticks until an interrupt appears; returns the tick count, or 0 if none within limit
   task automatic measure_period(int limit, output int n);
      bit hit;
      n = 0;
      for (int i = 1; i <= limit; i++) begin
         tick_once(hit);
         if (hit) begin
            n = i;
            break;
         end
      end
   endtask

   task automatic t_reset;
      logic [7:0] d;
      check("R1 irq after reset", int'(irq), 0);
      check("R1 rd_data after reset", int'(rd_data), 0);
      bus_read(8'h26, d); check("R1 count low", int'(d), 0);
      bus_read(8'h27, d); check("R1 hold", int'(d), 0);
      bus_read(8'h28, d); check("R1 period low", int'(d), 0);
      bus_read(8'h29, d); check("R1 period high", int'(d), 0);
   endtask

   task automatic t_period_write;
      logic [7:0] d;
      bus_write(8'h28, 8'h34);
      bus_read(8'h28, d); check("R9 staged byte not visible", int'(d), 0);
      bus_write(8'h29, 8'hF2);
      bus_read(8'h29, d); check("R10 period high reserved bits", int'(d), 8'h02);
      bus_read(8'h28, d); check("R8 period low committed", int'(d), 8'h34);
      @(negedge clk);
      check("R12 read data holds", int'(rd_data), 8'h34);
   endtask

   task automatic t_first_load;
      bit hit;
      logic [7:0] d;
      tick_once(hit); check("R3 irq on zero-count tick", int'(hit), 1);
      @(negedge clk); check("R3 irq single cycle", int'(irq), 0);
      bus_read(8'h26, d); check("R5 loaded count low", int'(d), 8'h34);
      bus_read(8'h27, d); check("R6 loaded count high", int'(d), 8'h02);
   endtask

   task automatic t_decrement;
      bit hit;
      logic [7:0] d;
      for (int i = 0; i < 5; i++) tick_once(hit);
      repeat (4) @(negedge clk);
      bus_read(8'h26, d); check("R2 count after 5 ticks", int'(d), 8'h2F);
   endtask

   task automatic t_coherent_read;
      bit hit;
      logic [7:0] d;
      bus_read(8'h26, d); check("R5 low byte", int'(d), 8'h2F);
      for (int i = 0; i < 8'h30; i++) tick_once(hit);
      bus_read(8'h27, d); check("R6 captured nibble, not live", int'(d), 8'h02);
      bus_read(8'h26, d); check("R5 low byte after ticks", int'(d), 8'hFF);
      bus_read(8'h27, d); check("R6 new capture", int'(d), 8'h01);
   endtask

   task automatic t_periods;
      int n;
      logic [7:0] d;
      bus_write(8'h28, 8'h03);
      bus_write(8'h29, 8'h00);
      measure_period(600, n); check("R3 drain from 0x1FF", n, 512);
      measure_period(40, n);  check("R3 period for P=3", n, 4);
      bus_write(8'h28, 8'h09);
      measure_period(40, n);  check("R7 low-only write keeps period", n, 4);
      bus_read(8'h28, d);     check("R7 period low unchanged", int'(d), 8'h03);
      bus_write(8'h29, 8'h00);
      measure_period(40, n);  check("R8 finish old period", n, 4);
      measure_period(40, n);  check("R8 new period P=9", n, 10);
   endtask

   task automatic t_readonly_writes;
      logic [7:0] d;
      bus_write(8'h26, 8'hAA);
      bus_write(8'h27, 8'hFF);
      bus_read(8'h26, d); check("R11 count low untouched", int'(d), 8'h09);
      bus_read(8'h27, d); check("R11 count high untouched", int'(d), 8'h00);
      bus_read(8'h28, d); check("R11 period low untouched", int'(d), 8'h09);
   endtask

   task automatic t_reserved;
      logic [7:0] d;
      bus_write(8'h29, 8'hF0);
      bus_read(8'h29, d); check("R10 reserved write dropped", int'(d), 8'h00);
      bus_write(8'h29, 8'hF1);
      bus_read(8'h29, d); check("R10 nibble kept", int'(d), 8'h01);
      bus_read(8'h28, d); check("R8 staged byte reused", int'(d), 8'h09);
   endtask

   task automatic t_zero_period;
      int n;
      logic [7:0] d;
      bus_write(8'h28, 8'h00);
      bus_write(8'h29, 8'h00);
      measure_period(40, n); check("R4 no irq with zero period", n, 0);
      bus_read(8'h26, d); check("R4 count stays zero low", int'(d), 0);
      bus_read(8'h27, d); check("R4 count stays zero high", int'(d), 0);
   endtask

   task automatic t_unmapped;
      logic [7:0] d;
      bus_read(8'h28, d);
      bus_read(8'h30, d); check("R12 unmapped read", int'(d), 0);
   endtask

   task automatic report;
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_period_write();
      t_first_load();
      t_decrement();
      t_coherent_read();
      t_periods();
      t_readonly_writes();
      t_reserved();
      t_zero_period();
      t_unmapped();
      report();
   end

   initial begin
      #(CLK_PERIOD * 100000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

endmodule